// File: doc/BRIEF.md
# Thermal Zone Supervisor With Shutdown

This block watches a die-temperature reading that arrives every so often as a signed value in whole degrees Celsius, together with a one-cycle valid strobe. For each valid sample it works out which of four thermal zones the die is in, and it decides whether the power amplifier may run. All outputs are registered. They change only on the clock edge that accepts a valid sample, and they hold between samples.

Each zone is a band between fixed thresholds. A separate hysteretic latch guards the amplifier. The latch turns the amplifier off when a sample is hotter than the trip point. It keeps the amplifier off until a sample falls below a lower release point. The latch raises a one-cycle event pulse when it shuts the amplifier down and another when it lets the amplifier run again. A power-management sequencer or an interrupt collector can use these pulses.

Top module: `thermal_supervisor`

## Requirements
- R1: Reset is synchronous and active low. While reset is held and on the first cycle after it: `zone` is 0, `pa_enable` is 1, `pa_shutdown` is 0, and both event pulses are 0.
- R2: The zone is updated from a valid sample and is seen on the cycle after the accepting edge. The code is 0 for a reading at or below 70, 1 for a reading above 70 and at or below 100, 2 for a reading above 100 and at or below 125, and 3 for a reading above 125. A reading equal to a threshold goes into the lower zone.
- R3: While `temp_valid` is 0, `zone`, `pa_enable` and `pa_shutdown` keep their values, whatever `temp_c` carries.
- R4: A valid sample above 170 while running sets `pa_shutdown` to 1 and `pa_enable` to 0. A sample of exactly 170 does not trip.
- R5: While shut down, a valid sample at or above 125 leaves the amplifier off. Only a valid sample below 125 sets `pa_enable` to 1 and `pa_shutdown` to 0.
- R6: `pa_enable` is always the complement of `pa_shutdown`.
- R7: `shutdown_evt` is high for exactly one cycle, on the cycle after the sample that trips. It is not raised by further hot samples while the amplifier is already shut down.
- R8: `recover_evt` is high for exactly one cycle, on the cycle after the sample that releases the shutdown. It is never high in the same cycle as `shutdown_evt`.
- R9: Negative readings are compared as signed values and give zone 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_valid | input | 1 | Strobe: `temp_c` holds a new reading this cycle |
| temp_c | input | TEMP_W (10) | Signed die temperature in °C |
| zone | output | 2 | Thermal zone code, 0 = coolest, 3 = hottest |
| pa_enable | output | 1 | Power amplifier may operate |
| pa_shutdown | output | 1 | Thermal shutdown is in force |
| shutdown_evt | output | 1 | One-cycle pulse when a shutdown begins |
| recover_evt | output | 1 | One-cycle pulse when a shutdown ends |

## Verification
The main sequence climbs the temperature through every threshold with a value exactly on the threshold and a value one degree above it. This separates "at threshold goes to the lower zone" from an off-by-one comparison. The sequence then passes 170 and comes back down through 150, 125 and 124. That separates a correct hysteretic release from a release at the zone-3 edge or at the trip point itself. A negative reading and a jump from far below to far above show whether the comparison is signed and whether the shutdown can skip the intermediate zones. Directed tests present changing readings with the strobe low, a second hot sample during a shutdown, and a reset in the middle of a shutdown. These show whether the outputs and pulses respond only to accepted samples.

// File: rtl/thermsup_pkg.sv
// Package: shared constants and types for the thermal supervisor.
// Assumes temperatures are signed whole degrees Celsius.
package thermsup_pkg;

    // Width of the signed temperature word.
    localparam int TEMP_W_DEF = 10;

    // Number of zone boundaries; there is one more zone than this.
    localparam int NUM_BOUNDS = 3;

    // Width of the zone code.
    localparam int ZONE_W = $clog2(NUM_BOUNDS + 1);

    // Zone codes, in order of rising temperature.
    typedef enum logic [ZONE_W-1:0] {
        ZONE_COOL = 2'd0,
        ZONE_WARM = 2'd1,
        ZONE_HOT  = 2'd2,
        ZONE_CRIT = 2'd3
    } zone_t;

endpackage

// File: rtl/thermal_zone_classifier.sv
// Module: thermal_zone_classifier
// Registers a zone code for each valid temperature sample.
// The code is the number of boundaries the reading exceeds.
// Assumes the boundaries are in ascending order, and that a reading equal
// to a boundary belongs to the lower zone.
module thermal_zone_classifier
    import thermsup_pkg::*;
#(
    parameter int                       TEMP_W = TEMP_W_DEF,
    parameter logic signed [TEMP_W-1:0] BOUND0 = 10'sd70,
    parameter logic signed [TEMP_W-1:0] BOUND1 = 10'sd100,
    parameter logic signed [TEMP_W-1:0] BOUND2 = 10'sd125
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [TEMP_W-1:0] sample_c,
    output zone_t                    zone_q
);

    localparam logic signed [TEMP_W-1:0] BOUNDS [NUM_BOUNDS] = '{BOUND0, BOUND1, BOUND2};

    logic [NUM_BOUNDS-1:0] above;
    logic [ZONE_W-1:0]     zone_next;

    // One signed comparator per boundary.
    for (genvar g = 0; g < NUM_BOUNDS; g++) begin : g_cmp
        assign above[g] = (sample_c > BOUNDS[g]);
    end

    // Count how many boundaries the reading exceeds.
    always_comb begin
        zone_next = '0;
        for (int i = 0; i < NUM_BOUNDS; i++) begin
            zone_next = zone_next + ZONE_W'(above[i]);
        end
    end

    // Hold the zone; load a new code only when a sample is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q <= ZONE_COOL;
        end else if (sample_valid) begin
            zone_q <= zone_t'(zone_next);
        end
    end

    // R3: without a sample, the zone does not move.
    assert_zone_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample_valid)) |-> $stable(zone_q));

    // R9: an accepted reading at or below zero gives the coolest zone.
    assert_cold_zone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_c <= 0) |=> (zone_q == ZONE_COOL));

endmodule

// File: rtl/thermal_trip_latch.sv
// Module: thermal_trip_latch
// Hysteretic shutdown control for the power amplifier.
// The latch trips when a sample is strictly above TRIP_C and releases when
// a sample is strictly below RELEASE_C. It emits one-cycle pulses on each
// change of state.
// Assumes RELEASE_C < TRIP_C.
module thermal_trip_latch
    import thermsup_pkg::*;
#(
    parameter int                       TEMP_W    = TEMP_W_DEF,
    parameter logic signed [TEMP_W-1:0] TRIP_C    = 10'sd170,
    parameter logic signed [TEMP_W-1:0] RELEASE_C = 10'sd125
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [TEMP_W-1:0] sample_c,
    output logic                     shut_q,
    output logic                     run_q,
    output logic                     trip_pulse_q,
    output logic                     release_pulse_q
);

    logic too_hot;
    logic cooled;

    // Compare against the two hysteresis points.
    always_comb begin
        too_hot = sample_valid && (sample_c > TRIP_C);
        cooled  = sample_valid && (sample_c < RELEASE_C);
    end

    // State and event registers. The pulses default low every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_q          <= 1'b0;
            run_q           <= 1'b1;
            trip_pulse_q    <= 1'b0;
            release_pulse_q <= 1'b0;
        end else begin
            trip_pulse_q    <= 1'b0;
            release_pulse_q <= 1'b0;
            if (!shut_q && too_hot) begin
                shut_q       <= 1'b1;
                run_q        <= 1'b0;
                trip_pulse_q <= 1'b1;
            end else if (shut_q && cooled) begin
                shut_q          <= 1'b0;
                run_q           <= 1'b1;
                release_pulse_q <= 1'b1;
            end
        end
    end

    // R4: a hot sample while running trips on the next cycle.
    assert_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shut_q && sample_valid && sample_c > TRIP_C) |=> (shut_q && !run_q));

    // R5: while shut down, a sample at or above the release point keeps it off.
    assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_q && sample_valid && sample_c >= RELEASE_C) |=> shut_q);

    // R6: the enable and the shutdown flag are complementary.
    assert_en_vs_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q != shut_q);

    // R7: the shutdown pulse lasts one cycle.
    assert_trip_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse_q |=> !trip_pulse_q);

    // R8: the recovery pulse lasts one cycle and never overlaps a trip pulse.
    assert_release_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse_q |=> !release_pulse_q);
    assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trip_pulse_q && release_pulse_q));

endmodule

// File: rtl/thermal_supervisor.sv
// Module: thermal_supervisor (top)
// Joins the zone classifier and the amplifier trip latch. Both take the
// same temperature sample stream.
// Assumes one sample per asserted temp_valid cycle.
module thermal_supervisor
    import thermsup_pkg::*;
#(
    parameter int                       TEMP_W      = TEMP_W_DEF,
    parameter logic signed [TEMP_W-1:0] ZONE_B0_C   = 10'sd70,
    parameter logic signed [TEMP_W-1:0] ZONE_B1_C   = 10'sd100,
    parameter logic signed [TEMP_W-1:0] ZONE_B2_C   = 10'sd125,
    parameter logic signed [TEMP_W-1:0] TRIP_C      = 10'sd170,
    parameter logic signed [TEMP_W-1:0] RELEASE_C   = 10'sd125
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] temp_c,
    output logic [ZONE_W-1:0]        zone,
    output logic                     pa_enable,
    output logic                     pa_shutdown,
    output logic                     shutdown_evt,
    output logic                     recover_evt
);

    zone_t zone_q;

    // Zone classification path.
    thermal_zone_classifier #(
        .TEMP_W (TEMP_W),
        .BOUND0 (ZONE_B0_C),
        .BOUND1 (ZONE_B1_C),
        .BOUND2 (ZONE_B2_C)
    ) u_zone (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (temp_valid),
        .sample_c     (temp_c),
        .zone_q       (zone_q)
    );

    // Amplifier shutdown path.
    thermal_trip_latch #(
        .TEMP_W    (TEMP_W),
        .TRIP_C    (TRIP_C),
        .RELEASE_C (RELEASE_C)
    ) u_trip (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_valid    (temp_valid),
        .sample_c        (temp_c),
        .shut_q          (pa_shutdown),
        .run_q           (pa_enable),
        .trip_pulse_q    (shutdown_evt),
        .release_pulse_q (recover_evt)
    );

    assign zone = zone_q;

    // R3: without a sample, the amplifier state does not move.
    assert_pa_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(temp_valid)) |-> $stable(pa_shutdown));

    // R7: while already shut down, no new shutdown pulse appears.
    assert_no_retrip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pa_shutdown)) |-> !shutdown_evt);

endmodule

// File: tb/tb_thermal_supervisor.sv
`timescale 1ns/1ps
// Bench: table-driven walk through zones and hysteresis, then directed tests.
module tb_thermal_supervisor;

    localparam int TW = 10;
    localparam int NV = 16;

    // Stimulus and expected results, one column per field.
    localparam int VT_TEMP [NV] = '{25, 70, 71, 100, 101, 125, 126, 170,
                                   171, 150, 125, 124, -40, 200, 60, 69};
    localparam int VT_ZONE [NV] = '{0, 0, 1, 1, 2, 2, 3, 3,
                                   3, 3, 2, 2, 0, 3, 0, 0};
    localparam int VT_EN   [NV] = '{1, 1, 1, 1, 1, 1, 1, 1,
                                   0, 0, 0, 1, 1, 0, 1, 1};
    localparam int VT_TRIP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                   1, 0, 0, 0, 0, 1, 0, 0};
    localparam int VT_REC  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                   0, 0, 0, 1, 0, 0, 1, 0};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 temp_valid = 1'b0;
    logic signed [TW-1:0] temp_c = '0;
    logic [1:0]           zone;
    logic                 pa_enable, pa_shutdown, shutdown_evt, recover_evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    thermal_supervisor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_valid   (temp_valid),
        .temp_c       (temp_c),
        .zone         (zone),
        .pa_enable    (pa_enable),
        .pa_shutdown  (pa_shutdown),
        .shutdown_evt (shutdown_evt),
        .recover_evt  (recover_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one valid sample. Return at the next negedge, where the
    // registered result is visible.
    task automatic sample(input int t);
        @(negedge clk);
        temp_c     = TW'(t);
        temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    initial begin
        // R1: reset state, held for a few cycles.
        repeat (3) @(negedge clk);
        check("R1 zone", int'(zone), 0);
        check("R1 pa_enable", int'(pa_enable), 1);
        check("R1 pa_shutdown", int'(pa_shutdown), 0);
        check("R1 events", int'(shutdown_evt) + int'(recover_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 zone after release", int'(zone), 0);
        check("R1 enable after release", int'(pa_enable), 1);

        // R2, R4, R5, R7, R8, R9: table walk.
        for (int i = 0; i < NV; i++) begin
            sample(VT_TEMP[i]);
            check($sformatf("R2 zone v%0d", i), int'(zone), VT_ZONE[i]);
            check($sformatf("R4/R5 enable v%0d", i), int'(pa_enable), VT_EN[i]);
            check($sformatf("R6 shutdown v%0d", i), int'(pa_shutdown), 1 - VT_EN[i]);
            check($sformatf("R7 trip evt v%0d", i), int'(shutdown_evt), VT_TRIP[i]);
            check($sformatf("R8 rec evt v%0d", i), int'(recover_evt), VT_REC[i]);
        end

        // R3: readings change without the strobe and have no effect.
        sample(180);
        check("R7 trip pulse", int'(shutdown_evt), 1);
        @(negedge clk);
        check("R7 pulse one cycle", int'(shutdown_evt), 0);
        temp_c = TW'(-20);
        repeat (4) @(negedge clk);
        check("R3 zone held", int'(zone), 3);
        check("R3 enable held", int'(pa_enable), 0);
        check("R3 shutdown held", int'(pa_shutdown), 1);
        check("R8 no event without sample", int'(recover_evt), 0);

        // R7: another hot sample while shut down raises no pulse.
        sample(190);
        check("R7 no retrip pulse", int'(shutdown_evt), 0);
        check("R4 still shut", int'(pa_shutdown), 1);

        // R5: exactly at the release point stays off; one below releases.
        sample(125);
        check("R5 at 125 stays off", int'(pa_enable), 0);
        sample(124);
        check("R8 recover pulse", int'(recover_evt), 1);
        check("R5 released", int'(pa_enable), 1);
        @(negedge clk);
        check("R8 pulse one cycle", int'(recover_evt), 0);

        // R4: exactly 170 does not trip.
        sample(170);
        check("R4 170 no trip", int'(pa_shutdown), 0);
        check("R4 170 no pulse", int'(shutdown_evt), 0);

        // R9: the most negative reading gives zone 0.
        sample(-512);
        check("R9 min reading zone", int'(zone), 0);

        // R1: a reset during a shutdown restores the reset state.
        sample(300);
        check("R4 trip before reset", int'(pa_shutdown), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears shutdown", int'(pa_shutdown), 0);
        check("R1 reset enables pa", int'(pa_enable), 1);
        check("R1 reset zone", int'(zone), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule